// File: doc/BRIEF.md
# Reconfigurable Region Boundary Isolator

This block sits on the edge of a region of logic that can be reloaded while the rest of the chip keeps running. Every signal that crosses between the static design and the region passes through a register, and all of those registers share one enable. A host writes a single control bit to close the boundary before it starts loading new configuration data into the region. It writes the bit again to open the boundary once loading has finished. While the boundary is closed, nothing the region drives can reach the static logic, and the region sees no transactions from the static side.

Data crosses the boundary in both directions as valid/ready streams. Each direction has a one-entry register slice. A word moves on any cycle in which both valid and ready are high at the clock edge. A slice accepts a new word when it is empty, or when the word it holds is being taken in the same cycle, so it can pass one word per cycle. A sender holding valid high must keep its data stable until ready is seen. A receiver that holds ready low stalls the slice. The stall then propagates back as ready low on the slice's input.

Each direction also carries a plain vector of flags, meant for request or strobe lines. These flags are registered once and are forced to zero while the boundary is closed. A status output reports whether the boundary is open or closed.

Top module: `rr_isolator`

## Requirements
- R1: After reset the boundary is open (`sts_closed`=0), both output valids are 0, both input readys are 1, and both flag outputs are 0.
- R2: A cycle with `ctl_wr`=1 loads `ctl_close` into the state. 1 means closed and 0 means open. `sts_closed` shows the new state starting in the cycle after that edge. It does not change in any cycle that follows an edge with `ctl_wr`=0.
- R3: While open, words accepted on `st_tx_*` appear on `rg_rx_*` in acceptance order with unchanged data, one cycle after acceptance at the earliest. None is lost or duplicated. While `rg_rx_valid`=1 and `rg_rx_ready`=0, the next cycle shows the same valid word.
- R4: While open, words accepted on `rg_tx_*` appear on `st_rx_*` under the same ordering, integrity and stall rules as R3.
- R5: While closed, `rg_rx_valid`=0 and `st_tx_ready`=0. `rg_rx_ready` has no effect.
- R6: While closed, `st_rx_valid`=0 and `rg_tx_ready`=0. `rg_tx_valid` and `rg_tx_data` have no effect, and `st_rx_data` holds its last value.
- R7: A word held in either slice when the boundary closes is kept. It is presented again, with the same data, in the first cycle after the boundary reopens.
- R8: While open, each flag output equals its flag input as sampled at the previous clock edge, provided the boundary was open at that edge.
- R9: Flag outputs are 0 in every cycle in which `sts_closed`=1. They are also 0 in the first cycle after reopening. Flag inputs sampled while closed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Host write strobe for the control bit |
| ctl_close | input | 1 | Control value: 1 close, 0 open |
| sts_closed | output | 1 | Current state: 1 closed, 0 open |
| st_tx_valid | input | 1 | Static-to-region word valid (static side) |
| st_tx_ready | output | 1 | Isolator can take a static-to-region word |
| st_tx_data | input | DATA_W | Static-to-region word |
| rg_rx_valid | output | 1 | Static-to-region word valid (region side) |
| rg_rx_ready | input | 1 | Region takes the word |
| rg_rx_data | output | DATA_W | Static-to-region word toward the region |
| rg_tx_valid | input | 1 | Region-to-static word valid (region side) |
| rg_tx_ready | output | 1 | Isolator can take a region-to-static word |
| rg_tx_data | input | DATA_W | Region-to-static word |
| st_rx_valid | output | 1 | Region-to-static word valid (static side) |
| st_rx_ready | input | 1 | Static logic takes the word |
| st_rx_data | output | DATA_W | Region-to-static word toward static logic |
| rg_flag_i | input | FLAG_W | Flags driven by the region |
| st_flag_o | output | FLAG_W | Registered region flags toward static logic |
| st_flag_i | input | FLAG_W | Flags driven by static logic |
| rg_flag_o | output | FLAG_W | Registered static flags toward the region |

## Verification
The bench builds the block with `DATA_W`=4 and `FLAG_W`=2. At that size every data code turns up many times in the stream sweeps, and the bench sweeps all 16 combinations of the two flag vectors both open and closed. The two streams run together under four valid/ready pattern mixes, including continuous flow, so both back-pressure and full-rate transfer are covered. Words left parked in both slices across a close and reopen cover the retention rule and the ignored-input rules.

// File: rtl/rr_iso_pkg.sv
package rr_iso_pkg;
  typedef enum logic {
    ISO_OPEN   = 1'b0,
    ISO_CLOSED = 1'b1
  } iso_state_e;
endpackage

// File: rtl/rr_iso_ctrl.sv
// Host-controlled open/closed state; drives the common enable.
module rr_iso_ctrl
  import rr_iso_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       close_i,
  output iso_state_e state_o,
  output logic       en_o
);
  iso_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= ISO_OPEN;
    else if (wr_i) state_q <= close_i ? ISO_CLOSED : ISO_OPEN;
  end

  assign state_o = state_q;
  assign en_o    = (state_q == ISO_OPEN);

  // R2: without a write the state never moves
  p_state_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(state_q));
endmodule

// File: rtl/rr_iso_slice.sv
// One-entry valid/ready register slice whose every update is gated by en_i.
module rr_iso_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         take, give;

  assign in_ready_o  = en_i & (~full_q | out_ready_i);
  assign out_valid_o = en_i & full_q;
  assign out_data_o  = data_q;
  assign take        = in_valid_i & in_ready_o;
  assign give        = out_valid_o & out_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take)      data_q <= in_data_i;
      if (take)      full_q <= 1'b1;
      else if (give) full_q <= 1'b0;
    end
  end

  // R3/R4: a stalled word stays put
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (full_q && $stable(data_q)));

  // R7: nothing moves in the slice while the boundary is closed
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(full_q) && $stable(data_q)));
endmodule

// File: rtl/rr_iso_flags.sv
// Registered flag vector, cleared and masked while the boundary is closed.
module rr_iso_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= en_i ? d_i : '0;
  end

  assign q_o = en_i ? q_q : '0;

  // R9: an edge taken while closed leaves the register clear
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (q_q == '0));

  // R8: open on two consecutive edges means a one-cycle copy of the input
  p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && $past(rst_n)) |-> (q_o == $past(d_i)));
endmodule

// File: rtl/rr_isolator.sv
module rr_isolator
  import rr_iso_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_close,
  output logic              sts_closed,
  input  logic              st_tx_valid,
  output logic              st_tx_ready,
  input  logic [DATA_W-1:0] st_tx_data,
  output logic              rg_rx_valid,
  input  logic              rg_rx_ready,
  output logic [DATA_W-1:0] rg_rx_data,
  input  logic              rg_tx_valid,
  output logic              rg_tx_ready,
  input  logic [DATA_W-1:0] rg_tx_data,
  output logic              st_rx_valid,
  input  logic              st_rx_ready,
  output logic [DATA_W-1:0] st_rx_data,
  input  logic [FLAG_W-1:0] rg_flag_i,
  output logic [FLAG_W-1:0] st_flag_o,
  input  logic [FLAG_W-1:0] st_flag_i,
  output logic [FLAG_W-1:0] rg_flag_o
);
  iso_state_e state;
  logic       en;

  rr_iso_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .close_i(ctl_close),
    .state_o(state), .en_o(en)
  );

  assign sts_closed = (state == ISO_CLOSED);

  // static -> region stream
  rr_iso_slice #(.W(DATA_W)) u_s2r (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .in_valid_i(st_tx_valid), .in_ready_o(st_tx_ready), .in_data_i(st_tx_data),
    .out_valid_o(rg_rx_valid), .out_ready_i(rg_rx_ready), .out_data_o(rg_rx_data)
  );

  // region -> static stream
  rr_iso_slice #(.W(DATA_W)) u_r2s (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .in_valid_i(rg_tx_valid), .in_ready_o(rg_tx_ready), .in_data_i(rg_tx_data),
    .out_valid_o(st_rx_valid), .out_ready_i(st_rx_ready), .out_data_o(st_rx_data)
  );

  rr_iso_flags #(.W(FLAG_W)) u_r2s_flags (
    .clk(clk), .rst_n(rst_n), .en_i(en), .d_i(rg_flag_i), .q_o(st_flag_o)
  );

  rr_iso_flags #(.W(FLAG_W)) u_s2r_flags (
    .clk(clk), .rst_n(rst_n), .en_i(en), .d_i(st_flag_i), .q_o(rg_flag_o)
  );

  // R5: static-to-region side fully quiet while the status reads closed
  p_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_closed |-> (!rg_rx_valid && !st_tx_ready && rg_flag_o == '0));

  // R6: region-to-static side fully quiet while the status reads closed
  p_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_closed |-> (!st_rx_valid && !rg_tx_ready && st_flag_o == '0));

  // R6: data toward static logic is held across closed cycles
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_closed && $past(sts_closed)) |-> $stable(st_rx_data));
endmodule

// File: tb/tb_rr_isolator.sv
module tb_rr_isolator;
  localparam int DW = 4;
  localparam int FW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, ctl_wr, ctl_close, sts_closed;
  logic          st_tx_valid, st_tx_ready, rg_rx_valid, rg_rx_ready;
  logic          rg_tx_valid, rg_tx_ready, st_rx_valid, st_rx_ready;
  logic [DW-1:0] st_tx_data, rg_rx_data, rg_tx_data, st_rx_data;
  logic [FW-1:0] rg_flag_i, st_flag_o, st_flag_i, rg_flag_o;

  rr_isolator #(.DATA_W(DW), .FLAG_W(FW)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] code_a(input int i);
    return DW'(i * 5 + 3);
  endfunction
  function automatic logic [DW-1:0] code_b(input int i);
    return DW'(i * 7 + 1);
  endfunction

  int tx_a = 0, rx_a = 0, tx_b = 0, rx_b = 0;
  bit stall_a = 0, stall_b = 0;
  logic [DW-1:0] sd_a, sd_b;

  // one open-boundary stream cycle in both directions
  task automatic stream_cycle(input bit va, input bit ra, input bit vb, input bit rb);
    @(negedge clk);
    st_tx_valid = va; st_tx_data = code_a(tx_a); rg_rx_ready = ra;
    rg_tx_valid = vb; rg_tx_data = code_b(tx_b); st_rx_ready = rb;
    #1;
    if (stall_a) chk(rg_rx_valid && rg_rx_data == sd_a, "R3 stall", int'(rg_rx_data), int'(sd_a));
    if (stall_b) chk(st_rx_valid && st_rx_data == sd_b, "R4 stall", int'(st_rx_data), int'(sd_b));
    stall_a = rg_rx_valid && !rg_rx_ready; sd_a = rg_rx_data;
    stall_b = st_rx_valid && !st_rx_ready; sd_b = st_rx_data;
    if (st_tx_valid && st_tx_ready) tx_a++;
    if (rg_tx_valid && rg_tx_ready) tx_b++;
    if (rg_rx_valid && rg_rx_ready) begin
      chk(rg_rx_data == code_a(rx_a), "R3 data", int'(rg_rx_data), int'(code_a(rx_a)));
      rx_a++;
    end
    if (st_rx_valid && st_rx_ready) begin
      chk(st_rx_data == code_b(rx_b), "R4 data", int'(st_rx_data), int'(code_b(rx_b)));
      rx_b++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ctl_wr = 0; ctl_close = 0;
    st_tx_valid = 0; st_tx_data = '0; rg_rx_ready = 0;
    rg_tx_valid = 0; rg_tx_data = '0; st_rx_ready = 0;
    rg_flag_i = '0; st_flag_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(!sts_closed, "R1 status", sts_closed, 0);
    chk(st_tx_ready && rg_tx_ready, "R1 readys", {st_tx_ready, rg_tx_ready}, 3);
    chk(!rg_rx_valid && !st_rx_valid, "R1 valids", {rg_rx_valid, st_rx_valid}, 0);
    chk(st_flag_o == 0 && rg_flag_o == 0, "R1 flags", {st_flag_o, rg_flag_o}, 0);

    // R3/R4 stream sweeps under four pattern mixes
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 48; c++)
        stream_cycle(m[0] | (c % 3 != 0), m[1] | (c % 2 == 0),
                     m[1] | (c % 4 != 1), m[0] | (c % 3 == 2));
    repeat (3) stream_cycle(0, 1, 0, 1);
    chk(rx_a == tx_a && tx_a > 100, "R3 count", rx_a, tx_a);
    chk(rx_b == tx_b && tx_b > 100, "R4 count", rx_b, tx_b);

    // park one word in each slice
    @(negedge clk);
    st_tx_valid = 1; st_tx_data = 4'hA; rg_rx_ready = 0;
    rg_tx_valid = 1; rg_tx_data = 4'h5; st_rx_ready = 0;
    #1 chk(st_tx_ready && rg_tx_ready, "R3 empty", {st_tx_ready, rg_tx_ready}, 3);
    @(negedge clk);
    st_tx_valid = 0; rg_tx_valid = 0; ctl_wr = 1; ctl_close = 1;
    #1;
    chk(!sts_closed, "R2 not yet", sts_closed, 0);
    chk(rg_rx_valid && rg_rx_data == 4'hA, "R3 parked", int'(rg_rx_data), 10);
    @(negedge clk);
    ctl_wr = 0;
    st_tx_valid = 1; st_tx_data = 4'hF; rg_rx_ready = 1;
    rg_tx_valid = 1; rg_tx_data = 4'hF; st_rx_ready = 1;
    #1;
    chk(sts_closed, "R2 closed", sts_closed, 1);
    // closed: sweep all flag combinations while streams are offered
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      rg_flag_i = FW'(v); st_flag_i = FW'(v >> 2);
      #1;
      chk(!rg_rx_valid && !st_tx_ready, "R5 quiet", {rg_rx_valid, st_tx_ready}, 0);
      chk(!st_rx_valid && !rg_tx_ready, "R6 quiet", {st_rx_valid, rg_tx_ready}, 0);
      chk(st_rx_data == 4'h5, "R6 hold", int'(st_rx_data), 5);
      chk(st_flag_o == 0 && rg_flag_o == 0, "R9 closed", {st_flag_o, rg_flag_o}, 0);
    end
    @(negedge clk);
    ctl_wr = 0; ctl_close = 0;
    #1;
    @(negedge clk);
    #1 chk(sts_closed, "R2 no write", sts_closed, 1);
    // reopen with readys low so parked words stay visible
    @(negedge clk);
    ctl_wr = 1; ctl_close = 0;
    st_tx_valid = 0; rg_tx_valid = 0; rg_rx_ready = 0; st_rx_ready = 0;
    @(negedge clk);
    ctl_wr = 0; rg_flag_i = 2'b11; st_flag_i = 2'b10;
    #1;
    chk(!sts_closed, "R2 open", sts_closed, 0);
    chk(rg_rx_valid && rg_rx_data == 4'hA, "R7 s2r kept", int'(rg_rx_data), 10);
    chk(st_rx_valid && st_rx_data == 4'h5, "R7 r2s kept", int'(st_rx_data), 5);
    chk(st_flag_o == 0 && rg_flag_o == 0, "R9 reopen", {st_flag_o, rg_flag_o}, 0);
    @(negedge clk);
    rg_rx_ready = 1; st_rx_ready = 1;
    #1;
    chk(st_flag_o == 2'b11, "R8 first", st_flag_o, 3);
    chk(rg_flag_o == 2'b10, "R8 first", rg_flag_o, 2);
    @(negedge clk);
    #1 chk(!rg_rx_valid && !st_rx_valid, "R7 drained", {rg_rx_valid, st_rx_valid}, 0);

    // R8 open flag sweep
    for (int v = 0; v < 17; v++) begin
      @(negedge clk);
      #1;
      if (v > 0) begin
        chk(st_flag_o == FW'(v - 1), "R8 region flags", st_flag_o, (v - 1) % 4);
        chk(rg_flag_o == FW'((v - 1) >> 2), "R8 static flags", rg_flag_o, ((v - 1) >> 2) % 4);
      end
      rg_flag_i = FW'(v); st_flag_i = FW'(v >> 2);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule